// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for one display channel. It runs on the pixel clock and keeps a horizontal pixel counter and a vertical line counter. From these it drives the horizontal and vertical sync pulses, a display-active qualifier and the current pixel coordinates. Software programs four packed timing words through a simple write port. Totals, display ends and sync starts are held as the value minus one. Sync widths and heights are held unencoded.

A written word goes into a pending copy first. The pending copy moves to the live copy only at a frame boundary, so a frame that is being scanned never sees half-updated timing. While timing is disabled, the live copy follows the pending copy on every clock. Each sync output has a phase input that selects active-high or active-low. A plane-enable input gates display-active without changing the counters.

Top module: `disp_timing_gen`

## Requirements
- R1: A write with `wr_en_i` high stores `wr_data_i` into the pending word chosen by `wr_addr_i`: 0 horizontal total, 1 horizontal sync, 2 vertical total, 3 vertical sync. In the total words, bits [CW-1:0] hold display end minus one and bits [2*CW-1:CW] hold total minus one. In the sync words, bits [CW-1:0] hold sync start minus one and bits [2*CW-1:CW] hold the sync width (in pixels) or height (in lines), unencoded.
- R2: While `timing_en_i` is high, `pix_x_o` advances by one each clock and returns to 0 on the clock after it equals the horizontal total field.
- R3: `pix_y_o` advances by one only on the clock where `pix_x_o` wraps, and returns to 0 when it wraps while equal to the vertical total field.
- R4: The internal horizontal sync is active for x in [S, S+W-1], where S is the sync-start field and W is the width field. W = 0 gives no pulse.
- R5: The internal vertical sync is active for whole lines y in [S, S+H-1], using the vertical sync fields in the same way.
- R6: `disp_active_o` is high only when timing is enabled, `plane_en_i` is high, x is at most the horizontal display-end field and y is at most the vertical display-end field.
- R7: `hsync_o` equals the internal horizontal sync when `hsync_pol_i` is 1 (active high) and its inverse when it is 0. `vsync_o` follows `vsync_pol_i` in the same way.
- R8: While `timing_en_i` is low, both counters are held at 0, both syncs sit at their inactive level and display-active is low.
- R9: A write made while timing runs takes effect only from the first pixel of the next frame; while timing is disabled, the live timing follows the pending words on every clock.
- R10: After a synchronous active-low reset, both counters are 0 and all pending and live fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Timing word select |
| wr_data_i | input | 2*CW | Packed timing word |
| timing_en_i | input | 1 | Run the counters |
| hsync_pol_i | input | 1 | 1 = horizontal sync active high |
| vsync_pol_i | input | 1 | 1 = vertical sync active high |
| plane_en_i | input | 1 | Graphics plane enable |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| disp_active_o | output | 1 | Display-active qualifier |
| pix_x_o | output | CW | Current pixel column |
| pix_y_o | output | CW | Current line |

## Verification
The assertions assume that the reset is held for at least one clock before any checked edge. They also assume that the live fields describe a non-empty raster, since the counter bound is read against whatever total is live. The stimulus programs every word while timing is disabled, or in the middle of a running frame. A change made mid-frame becomes visible only through the frame-boundary load, and the bench model has to reproduce exactly that cycle. Sync windows are chosen to fit inside the totals. One pass uses a zero width so that the no-pulse corner is covered.

// File: rtl/disp_timing_pkg.sv
// Shared definitions for the display timing generator.
// Assumes a two-bit word select on the write port.
package disp_timing_pkg;

    typedef enum logic [1:0] {
        WORD_H_TOTAL = 2'd0,
        WORD_H_SYNC  = 2'd1,
        WORD_V_TOTAL = 2'd2,
        WORD_V_SYNC  = 2'd3
    } word_sel_e;

    localparam int NUM_WORDS = 4;

    // Drive a sync pin from its internal active flag and its phase bit.
    function automatic logic apply_phase(input logic active, input logic high_active);
        return high_active ? active : ~active;
    endfunction

endpackage

// File: rtl/disp_timing_regs.sv
// Pending and live copies of the four timing words.
// Assumes load_i is high at a frame boundary or while timing is idle.
// A write and a load in the same cycle give the live copy the old pending value.
module disp_timing_regs #(
    parameter int CW = 12,
    localparam int DW = 2 * CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          load_i,
    output logic [DW-1:0] h_total_o,
    output logic [DW-1:0] h_sync_o,
    output logic [DW-1:0] v_total_o,
    output logic [DW-1:0] v_sync_o
);
    import disp_timing_pkg::*;

    logic [DW-1:0] pend_q [NUM_WORDS];
    logic [DW-1:0] live_q [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        // Capture writes into the pending copy of word i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[i] <= '0;
            else if (wr_en_i && (wr_addr_i == 2'(i)))
                pend_q[i] <= wr_data_i;
        end

        // Move pending into live at a frame boundary.
        always_ff @(posedge clk) begin
            if (!rst_n)
                live_q[i] <= '0;
            else if (load_i)
                live_q[i] <= pend_q[i];
        end

        // R9
        live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !load_i |=> $stable(live_q[i]));
    end

    assign h_total_o = live_q[WORD_H_TOTAL];
    assign h_sync_o  = live_q[WORD_H_SYNC];
    assign v_total_o = live_q[WORD_V_TOTAL];
    assign v_sync_o  = live_q[WORD_V_SYNC];

endmodule

// File: rtl/disp_timing_axis.sv
// One raster axis: a position counter and its window decodes.
// Assumes step_i marks an advance and run_i low forces the position to zero.
// Sync window is [ss, ss+sw); display window is [0, de].
module disp_timing_axis #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          step_i,
    input  logic [CW-1:0] total_m1_i,
    input  logic [CW-1:0] de_m1_i,
    input  logic [CW-1:0] ss_m1_i,
    input  logic [CW-1:0] sw_i,
    output logic [CW-1:0] pos_o,
    output logic          last_o,
    output logic          in_disp_o,
    output logic          in_sync_o
);
    logic [CW-1:0] pos_q;
    logic [CW:0]   sync_end;

    // Advance, wrap or clear the position counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            pos_q <= '0;
        else if (step_i)
            pos_q <= last_o ? '0 : pos_q + 1'b1;
    end

    // Decode the end of the axis and the two windows.
    always_comb begin
        sync_end  = {1'b0, ss_m1_i} + {1'b0, sw_i};
        last_o    = (pos_q == total_m1_i);
        in_disp_o = (pos_q <= de_m1_i);
        in_sync_o = ({1'b0, pos_q} >= {1'b0, ss_m1_i}) && ({1'b0, pos_q} < sync_end);
    end

    assign pos_o = pos_q;

    // R2
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (pos_q <= total_m1_i));
    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && step_i && last_o) |=> (pos_q == '0));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !step_i) |=> (pos_q == '0 || $stable(pos_q)));
    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (pos_q == '0));

endmodule

// File: rtl/disp_timing_gen.sv
// Display timing generator top: registers, two axes and the output stage.
// Assumes the live fields describe a raster whose sync windows fit the totals.
module disp_timing_gen #(
    parameter int CW = 12,
    localparam int DW = 2 * CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          timing_en_i,
    input  logic          hsync_pol_i,
    input  logic          vsync_pol_i,
    input  logic          plane_en_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          disp_active_o,
    output logic [CW-1:0] pix_x_o,
    output logic [CW-1:0] pix_y_o
);
    import disp_timing_pkg::*;

    logic [DW-1:0] h_total, h_sync, v_total, v_sync;
    logic          h_last, v_last, h_disp, v_disp, h_syn, v_syn;
    logic          frame_end, load;

    // Reload the live words at the frame end or while idle.
    assign frame_end = timing_en_i && h_last && v_last;
    assign load      = !timing_en_i || frame_end;

    disp_timing_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .load_i    (load),
        .h_total_o (h_total),
        .h_sync_o  (h_sync),
        .v_total_o (v_total),
        .v_sync_o  (v_sync)
    );

    disp_timing_axis #(.CW(CW)) u_h_axis (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (timing_en_i),
        .step_i     (1'b1),
        .total_m1_i (h_total[DW-1:CW]),
        .de_m1_i    (h_total[CW-1:0]),
        .ss_m1_i    (h_sync[CW-1:0]),
        .sw_i       (h_sync[DW-1:CW]),
        .pos_o      (pix_x_o),
        .last_o     (h_last),
        .in_disp_o  (h_disp),
        .in_sync_o  (h_syn)
    );

    disp_timing_axis #(.CW(CW)) u_v_axis (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (timing_en_i),
        .step_i     (h_last),
        .total_m1_i (v_total[DW-1:CW]),
        .de_m1_i    (v_total[CW-1:0]),
        .ss_m1_i    (v_sync[CW-1:0]),
        .sw_i       (v_sync[DW-1:CW]),
        .pos_o      (pix_y_o),
        .last_o     (v_last),
        .in_disp_o  (v_disp),
        .in_sync_o  (v_syn)
    );

    // Gate the windows by the enables and apply the sync phases.
    always_comb begin
        hsync_o       = apply_phase(timing_en_i && h_syn, hsync_pol_i);
        vsync_o       = apply_phase(timing_en_i && v_syn, vsync_pol_i);
        disp_active_o = timing_en_i && plane_en_i && h_disp && v_disp;
    end

    // R6
    active_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_active_o |-> (plane_en_i && timing_en_i));
    // R8
    idle_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !timing_en_i |-> (hsync_o == !hsync_pol_i && vsync_o == !vsync_pol_i));
    // R3
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (pix_x_o == '0 && pix_y_o == '0));

endmodule

// File: tb/disp_timing_gen_tb.sv
// Cycle model sweep of the display timing generator in a small configuration.
module disp_timing_gen_tb;
    localparam int CW = 8;
    localparam int DW = 2 * CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          ten = 1'b0, hpol = 1'b1, vpol = 1'b1, pen = 1'b1;
    logic          hs, vs, act;
    logic [CW-1:0] px, py;

    int errors = 0, checks = 0;
    int pend_lo [4], pend_hi [4], live_lo [4], live_hi [4];
    int mx = 0, my = 0;
    string tag = "R10";

    always #2.5 clk = ~clk;

    disp_timing_gen #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .timing_en_i(ten), .hsync_pol_i(hpol),
        .vsync_pol_i(vpol), .plane_en_i(pen), .hsync_o(hs), .vsync_o(vs),
        .disp_active_o(act), .pix_x_o(px), .pix_y_o(py)
    );

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s/%s: got %0d expected %0d (x=%0d y=%0d)", req, tag, got, exp, mx, my);
        end
    endtask

    // Compare every output against the model.
    task automatic check_all();
        int hw, vw, eh, ev, ea;
        hw = (ten && mx >= live_lo[1] && mx < live_lo[1] + live_hi[1]) ? 1 : 0;
        vw = (ten && my >= live_lo[3] && my < live_lo[3] + live_hi[3]) ? 1 : 0;
        eh = hpol ? hw : 1 - hw;
        ev = vpol ? vw : 1 - vw;
        ea = (ten && pen && mx <= live_lo[0] && my <= live_lo[2]) ? 1 : 0;
        chk("R2", int'(px), mx);
        chk("R3", int'(py), my);
        chk("R4", int'(hs), eh);
        chk("R5", int'(vs), ev);
        chk("R6", int'(act), ea);
        chk("R7", int'(hs ^ vs), eh ^ ev);
    endtask

    // One clock: advance the model from pre-edge state, then check.
    task automatic tick();
        int nx, ny;
        nx = mx + 1; ny = my;
        if (!ten || (mx == live_hi[0] && my == live_hi[2])) begin
            nx = 0; ny = 0;
            for (int i = 0; i < 4; i++) begin live_lo[i] = pend_lo[i]; live_hi[i] = pend_hi[i]; end
        end else if (mx == live_hi[0]) begin
            nx = 0; ny = my + 1;
        end
        if (wr_en) begin
            pend_lo[wr_addr] = int'(wr_data[CW-1:0]);
            pend_hi[wr_addr] = int'(wr_data[DW-1:CW]);
        end
        @(posedge clk);
        mx = nx; my = ny;
        @(negedge clk);
        wr_en = 1'b0;
        check_all();
    endtask

    task automatic wr(int a, int hi, int lo);
        wr_en = 1'b1; wr_addr = 2'(a);
        wr_data = {CW'(hi), CW'(lo)};
        tick();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin pend_lo[i] = 0; pend_hi[i] = 0; live_lo[i] = 0; live_hi[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check_all();
        // R1 program while idle: h total 10 de 6, hsync start 7 width 2
        tag = "R1";
        wr(0, 9, 5); wr(1, 2, 6); wr(2, 4, 2); wr(3, 1, 3);
        run(2);
        // R8 idle then R2/R3 sweep for two frames
        tag = "R2";
        ten = 1'b1;
        run(100);
        // R9 mid-frame change: shorter line, zero-width hsync
        tag = "R9";
        run(13);
        wr(0, 7, 3); wr(1, 0, 4);
        run(120);
        // R7 phase flips and R6 plane gating
        tag = "R7";
        hpol = 1'b0; vpol = 1'b0;
        run(45);
        pen = 1'b0;
        run(45);
        pen = 1'b1;
        // R5 tall vsync reaching the last line, sync at the line end
        tag = "R5";
        wr(3, 2, 3); wr(1, 1, 7);
        run(90);
        // R8 disable mid-frame, then restart
        tag = "R8";
        ten = 1'b0;
        run(6);
        ten = 1'b1;
        run(60);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule